// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead-Time Insertion

This block sits between a PWM source and the gate drivers of one inverter leg. It takes three synchronous bits per leg: a high-side command that is active high, a low-side command that is active low, and a shutdown bit that is active low. It produces two registered gate-enable bits, one for the low-side switch and one for the high-side switch. Any combination that would turn on both switches, or that asks for neither, turns both gates off. A low shutdown bit forces both gates off whatever the commands are.

Every turn-on is delayed until both gates have been low for a programmable number of clock cycles. This is the dead time, and it is counted from the last cycle in which a gate was on. A turn-off always takes effect at the next clock edge. If the commands change together, or close together, the incoming switch therefore waits a full dead time after the outgoing switch has dropped. If a command arrives long after both gates went low, the gate follows it at once.

Top module: `hb_gate_ctrl`

## Requirements
- R1: When `sd_n` is 0 at a rising edge, both `lo_gate` and `hi_gate` are 0 after that edge, whatever the two commands are.
- R2: When `sd_n`=1, `hi_cmd`=1 and `lo_cmd_n`=0 (both switches requested), both outputs are 0 after the edge.
- R3: When `sd_n`=1, `hi_cmd`=0 and `lo_cmd_n`=1 (no switch requested), both outputs are 0 after the edge.
- R4: When `sd_n`=1, `hi_cmd`=0 and `lo_cmd_n`=0, the low side is requested. `hi_gate` is 0 after the edge, and `lo_gate` is 1 once the dead-time condition of R7 allows it.
- R5: When `sd_n`=1, `hi_cmd`=1 and `lo_cmd_n`=1, the high side is requested. `lo_gate` is 0 after the edge, and `hi_gate` is 1 once the dead-time condition of R7 allows it.
- R6: `lo_gate` and `hi_gate` are never 1 in the same cycle.
- R7: A gate rises only after both outputs have been 0 for at least `DEAD_CYC` consecutive cycles. When the requests swap directly, or swap within `DEAD_CYC` cycles, the outgoing gate drops at the next edge and the incoming gate rises exactly `DEAD_CYC` edges after that drop.
- R8: A request that arrives after both gates have already been low for at least `DEAD_CYC` cycles turns its gate on at the next edge, with no extra delay.
- R9: During reset both outputs are 0. With a request held from the release of reset onward, the gate rises at the `DEAD_CYC`-th rising edge after release, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sd_n | input | 1 | Shutdown request, active low |
| hi_cmd | input | 1 | High-side command, active high |
| lo_cmd_n | input | 1 | Low-side command, active low |
| lo_gate | output | 1 | Registered low-side gate enable |
| hi_gate | output | 1 | Registered high-side gate enable |

## Verification
The bench builds the block with `DEAD_CYC`=4. At that size every spacing between command edges can be swept, from simultaneous edges up to spacings longer than the dead time: gaps of 0 to `DEAD_CYC`+2 cycles are driven through both the idle combination and the interlock combination. The bench also applies every ordered pair of the eight input combinations, holding the second combination for 1 to `DEAD_CYC`+2 cycles. After each edge the outputs are compared with an arithmetic model that counts consecutive off cycles. A short dead time also makes the reset-to-first-turn-on count easy to check edge by edge.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_LOW  = 2'd1,
        REQ_HIGH = 2'd2
    } side_req_e;

    typedef struct packed {
        logic lo_on;
        logic hi_on;
    } gate_pair_t;

endpackage

// File: rtl/hb_req_decode.sv
module hb_req_decode
    import hb_pkg::*;
(
    input  logic      sd_n,
    input  logic      hi_cmd,
    input  logic      lo_cmd_n,
    output side_req_e req
);

    // Map the three control bits onto one side request; any illegal
    // or idle combination resolves to no request.
    always_comb begin
        req = REQ_NONE;
        if (sd_n) begin
            unique case ({hi_cmd, lo_cmd_n})
                2'b00:   req = REQ_LOW;
                2'b11:   req = REQ_HIGH;
                default: req = REQ_NONE;
            endcase
        end
    end

endmodule

// File: rtl/hb_off_timer.sv
module hb_off_timer #(
    parameter int unsigned DEAD_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gates_off,
    output logic expired
);

    localparam int unsigned CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEAD_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == LIMIT);

    // Counts the cycles both gates have been low; cleared while any gate
    // is on, held once the limit is reached.
    always_comb begin
        cnt_d = cnt_q;
        if (!gates_off) begin
            cnt_d = '0;
        end else if (!expired) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/hb_gate_arbiter.sv
module hb_gate_arbiter
    import hb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  side_req_e req,
    input  logic      expired,
    output logic      lo_gate,
    output logic      hi_gate
);

    gate_pair_t gate_d, gate_q;

    // A gate stays on while it remains requested; it may come on only when
    // the opposite gate is off and the off-time counter has expired.
    always_comb begin
        gate_d       = gate_q;
        gate_d.lo_on = (req == REQ_LOW)
                     && (gate_q.lo_on || (!gate_q.hi_on && expired));
        gate_d.hi_on = (req == REQ_HIGH)
                     && (gate_q.hi_on || (!gate_q.lo_on && expired));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign lo_gate = gate_q.lo_on;
    assign hi_gate = gate_q.hi_on;

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_n,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    output logic lo_gate,
    output logic hi_gate
);

    side_req_e req;
    logic      expired;
    logic      lo_q, hi_q;

    hb_req_decode u_decode (
        .sd_n     (sd_n),
        .hi_cmd   (hi_cmd),
        .lo_cmd_n (lo_cmd_n),
        .req      (req)
    );

    hb_off_timer #(
        .DEAD_CYC (DEAD_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .gates_off (!lo_q && !hi_q),
        .expired   (expired)
    );

    hb_gate_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .expired (expired),
        .lo_gate (lo_q),
        .hi_gate (hi_q)
    );

    assign lo_gate = lo_q;
    assign hi_gate = hi_q;

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
    parameter int unsigned DEAD_CYC = 120
) (
    input logic clk,
    input logic rst_n,
    input logic sd_n,
    input logic hi_cmd,
    input logic lo_cmd_n,
    input logic lo_gate,
    input logic hi_gate
);

    localparam int unsigned RUN_W = $clog2(DEAD_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEAD_CYC);

    // Independent count of consecutive cycles with both outputs low.
    logic [RUN_W-1:0] off_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run_q <= '0;
        end else if (lo_gate || hi_gate) begin
            off_run_q <= '0;
        end else if (off_run_q != RUN_MAX) begin
            off_run_q <= off_run_q + RUN_W'(1);
        end
    end

    p_shutdown_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_n |=> (!lo_gate && !hi_gate));

    p_interlock_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_n && hi_cmd && !lo_cmd_n) |=> (!lo_gate && !hi_gate));

    p_idle_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_n && !hi_cmd && lo_cmd_n) |=> (!lo_gate && !hi_gate));

    p_low_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_n && !hi_cmd && !lo_cmd_n) |=> !hi_gate);

    p_high_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_n && hi_cmd && lo_cmd_n) |=> !lo_gate);

    p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_gate && hi_gate));

    p_deadtime_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lo_gate) || $rose(hi_gate)) |-> (off_run_q >= RUN_MAX));

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(
    .DEAD_CYC (DEAD_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_n     (sd_n),
    .hi_cmd   (hi_cmd),
    .lo_cmd_n (lo_cmd_n),
    .lo_gate  (lo_gate),
    .hi_gate  (hi_gate)
);

// File: tb/hb_gate_ctrl_tb.sv
module hb_gate_ctrl_tb;

    localparam int DT      = 4;
    localparam int CLK_PER = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd_n = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd_n = 1'b1;
    logic lo_gate, hi_gate;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state: expected outputs and consecutive off-cycle count
    bit m_lo = 1'b0;
    bit m_hi = 1'b0;
    int m_run = 0;

    always #(CLK_PER/2) clk = ~clk;

    hb_gate_ctrl #(.DEAD_CYC(DT)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sd_n     (sd_n),
        .hi_cmd   (hi_cmd),
        .lo_cmd_n (lo_cmd_n),
        .lo_gate  (lo_gate),
        .hi_gate  (hi_gate)
    );

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic s, input logic h, input logic ln);
        if (!s)            return "R1";
        else if (h && !ln) return "R2";
        else if (!h && ln) return "R3";
        else if (!h)       return "R4";
        else               return "R5";
    endfunction

    // Apply one input combination for one clock, advance the model, compare.
    task automatic step(input logic s, input logic h, input logic ln);
        int run_now;
        bit want_lo, want_hi;
        string tg;
        sd_n = s; hi_cmd = h; lo_cmd_n = ln;
        @(posedge clk);
        want_lo = s && !h && !ln;
        want_hi = s && h && ln;
        run_now = (!m_lo && !m_hi) ? m_run + 1 : 0;
        // R7/R8: a requested gate comes on once DT off cycles have elapsed
        m_lo = want_lo && (m_lo || run_now >= DT);
        m_hi = want_hi && (m_hi || run_now >= DT);
        m_run = (run_now > DT) ? DT : run_now;
        @(negedge clk);
        tg = tag_of(s, h, ln);
        check(tg, "lo_gate", lo_gate, m_lo);
        check(tg, "hi_gate", hi_gate, m_hi);
        check("R6", "both_on", lo_gate && hi_gate, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_lo = 1'b0; m_hi = 1'b0; m_run = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", "lo_gate_in_reset", lo_gate, 1'b0);
        check("R9", "hi_gate_in_reset", hi_gate, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        // R9: first turn-on after release waits exactly DT edges (low side)
        for (int k = 1; k <= DT; k++) begin
            step(1'b1, 1'b0, 1'b0);
            check("R9", "lo_first_on", lo_gate, (k == DT));
        end

        // R9 again, high side, reset taken while the low gate is on
        do_reset();
        for (int k = 1; k <= DT; k++) begin
            step(1'b1, 1'b1, 1'b1);
            check("R9", "hi_first_on", hi_gate, (k == DT));
        end

        // R7/R8: swap from high to low with a gap of g cycles, through the
        // idle combination (v=0) and through the interlock combination (v=1)
        for (int v = 0; v < 2; v++) begin
            for (int g = 0; g <= DT + 2; g++) begin
                int seen;
                int expect_at;
                repeat (DT + 2) step(1'b1, 1'b1, 1'b1);
                seen = 0;
                expect_at = ((g > DT) ? g : DT) + 1;
                for (int k = 1; k <= DT + g + 3; k++) begin
                    if (k <= g) begin
                        if (v == 0) step(1'b1, 1'b0, 1'b1);
                        else        step(1'b1, 1'b1, 1'b0);
                    end else begin
                        step(1'b1, 1'b0, 1'b0);
                    end
                    if (k == 1) check("R7", "hi_drops_next_edge", hi_gate, 1'b0);
                    if (lo_gate && seen == 0) seen = k;
                end
                checks++;
                if (seen != expect_at) begin
                    failures++;
                    $display("FAIL %s lo_rise_step actual=%0d expected=%0d gap=%0d",
                             (g >= DT) ? "R8" : "R7", seen, expect_at, g);
                end
            end
        end

        // All ordered pairs of input combinations, second held 1..DT+2 cycles
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int h = 1; h <= DT + 2; h++) begin
                    repeat (DT + 2) step(a[2], a[1], a[0]);
                    repeat (h) step(b[2], b[1], b[0]);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule